// File: doc/BRIEF.md
# TDM Switch Output Channel Controller

This block drives the serial output streams of a time-slot interchange switch with 8 streams of 32 eight-bit channels. A connection memory holds one high word and one low word for each output stream and channel. For every output channel the block sends one of three things: a time slot switched out of the data memory, a fixed byte taken from the low connection word, or nothing (high impedance). An internal bit counter, restarted by a frame pulse, walks the channels and shifts each byte out most significant bit first.

Input capture is modelled as a parallel write port into a double-buffered data memory. Bytes written during one frame become readable only after the next frame pulse, so switched data arrives one frame late. A CPU port reaches a control word and, through it, the high connection, low connection or data memory of one stream. The control word can also force every channel into message mode or switch the CPU port into split access.

Top module: `tdm_out_ctrl`

## Requirements
- R1: After reset every `ser_oe_o` and `ser_o` bit is 0, and the control word reads back as 0.
- R2: The cycle after `frame_i` is sampled high carries channel 0, bit 7. Each following cycle carries the next lower bit. Channels run 0 to 31, with 8 bits each, and the count wraps after 256 cycles.
- R3: When high-word bit 2 is 0, the channel carries the live data-memory byte at stream high[5:3] and channel low[4:0].
- R4: Input writes land in the capture bank. The banks swap on every cycle where `frame_i` is high. A write in that same cycle lands in the bank that becomes live.
- R5: When high-word bit 2 is 1, the channel carries the low connection byte in every frame.
- R6: High-word bit 0 set to 1 drives the channel (`ser_oe_o` high). Set to 0, the channel is high impedance.
- R7: While `drive_en_i` is 0, every `ser_oe_o` is 0, whatever the connection words hold.
- R8: Control bit 6 makes every channel behave as if its high-word bits 2 and 0 were both 1.
- R9: With control bit 7 set, CPU reads at addr[7]=1 return the live data byte, and CPU writes go to the low connection memory, whatever the select field holds.
- R10: addr[7]=0 reaches the control word. With addr[7]=1, addr[4:0] is the channel and control[2:0] is the stream. Control[4:3] selects the memory: 01 is connection low, 10 is connection high, and 00 or 11 is the data memory, which the CPU can read but not write.
- R11: While a stream's `ser_oe_o` is 0, its `ser_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Frame pulse; restarts the counter and swaps the data banks |
| drive_en_i | input | 1 | Global drive enable; 0 forces every output to high impedance |
| in_we_i | input | 1 | Capture write strobe |
| in_stream_i | input | 3 | Capture stream index |
| in_chan_i | input | 5 | Capture channel index |
| in_data_i | input | 8 | Captured byte |
| cpu_we_i | input | 1 | CPU write strobe |
| cpu_addr_i | input | 8 | CPU address |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | CPU read data (combinational) |
| ser_o | output | 8 | Serial data bit per stream |
| ser_oe_o | output | 8 | Drive enable per stream |

## Verification
A capture write and a frame pulse can fall in the same cycle. The bench raises `in_we_i` and `frame_i` together and then reads the data memory through the CPU port. The byte must already be visible, because it went into the bank that turned live at that edge. A CPU write to a connection word can also land while that channel is being serialised. Each frame is therefore checked only after the configuration has settled, against bit-level expectations built from the written words, the live bank and the control bits.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  typedef enum logic [1:0] {
    SEL_DATA  = 2'b00,
    SEL_LOW   = 2'b01,
    SEL_HIGH  = 2'b10,
    SEL_DATA2 = 2'b11
  } memsel_e;

  localparam int CTRL_SPLIT  = 7;
  localparam int CTRL_MSGALL = 6;
  localparam int CTRL_SEL    = 3;
  localparam int HI_MSG      = 2;
  localparam int HI_OE       = 0;
  localparam int HI_SRC      = 3;
endpackage

// File: rtl/tdm_frame_ctr.sv
module tdm_frame_ctr #(
  parameter int N_CHANS = 32,
  parameter int DW      = 8,
  localparam int CHW    = $clog2(N_CHANS),
  localparam int BW     = $clog2(DW)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           frame_i,
  output logic [CHW-1:0] chan_o,
  output logic [BW-1:0]  bitpos_o
);
  localparam int CW = CHW + BW;
  localparam logic [CW-1:0] LAST = CW'(N_CHANS * DW - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (frame_i)        cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign chan_o   = cnt_q[CW-1:BW];
  // MSB first
  assign bitpos_o = BW'(DW - 1) - cnt_q[BW-1:0];
endmodule

// File: rtl/tdm_conn_mem.sv
module tdm_conn_mem
  import tdm_pkg::*;
#(
  parameter int N_STREAMS = 8,
  parameter int N_CHANS   = 32,
  parameter int DW        = 8,
  parameter int AW        = 8,
  localparam int SW       = $clog2(N_STREAMS),
  localparam int CHW      = $clog2(N_CHANS)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [CHW-1:0] chan_i,
  output logic [DW-1:0]  hi_o   [N_STREAMS],
  output logic [DW-1:0]  lo_o   [N_STREAMS],
  output logic [DW-1:0]  ctrl_o,
  output logic [DW-1:0]  rdata_o
);
  logic [DW-1:0] hi_q [N_STREAMS][N_CHANS];
  logic [DW-1:0] lo_q [N_STREAMS][N_CHANS];
  logic [DW-1:0] ctrl_q;

  logic           mem_acc;
  logic [CHW-1:0] ach;
  logic [SW-1:0]  cs;
  memsel_e        sel;

  assign mem_acc = addr_i[AW-1];
  assign ach     = addr_i[CHW-1:0];
  assign cs      = ctrl_q[SW-1:0];
  assign sel     = memsel_e'(ctrl_q[CTRL_SEL +: 2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      for (int s = 0; s < N_STREAMS; s++)
        for (int c = 0; c < N_CHANS; c++) begin
          hi_q[s][c] <= '0;
          lo_q[s][c] <= '0;
        end
    end else if (we_i) begin
      if (!mem_acc)                 ctrl_q       <= wdata_i;
      else if (ctrl_q[CTRL_SPLIT])  lo_q[cs][ach] <= wdata_i;
      else if (sel == SEL_LOW)      lo_q[cs][ach] <= wdata_i;
      else if (sel == SEL_HIGH)     hi_q[cs][ach] <= wdata_i;
    end
  end

  for (genvar s = 0; s < N_STREAMS; s++) begin : g_rd
    assign hi_o[s] = hi_q[s][chan_i];
    assign lo_o[s] = lo_q[s][chan_i];
  end

  assign ctrl_o  = ctrl_q;
  assign rdata_o = (sel == SEL_HIGH) ? hi_q[cs][ach] : lo_q[cs][ach];
endmodule

// File: rtl/tdm_data_mem.sv
module tdm_data_mem #(
  parameter int N_STREAMS = 8,
  parameter int N_CHANS   = 32,
  parameter int DW        = 8,
  localparam int SW       = $clog2(N_STREAMS),
  localparam int CHW      = $clog2(N_CHANS)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           frame_i,
  input  logic           we_i,
  input  logic [SW-1:0]  wstream_i,
  input  logic [CHW-1:0] wchan_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [SW-1:0]  rd_stream_i [N_STREAMS],
  input  logic [CHW-1:0] rd_chan_i   [N_STREAMS],
  output logic [DW-1:0]  rd_data_o   [N_STREAMS],
  input  logic [SW-1:0]  cpu_stream_i,
  input  logic [CHW-1:0] cpu_chan_i,
  output logic [DW-1:0]  cpu_data_o
);
  logic [DW-1:0] mem_q [2][N_STREAMS][N_CHANS];
  logic          live_q;

  // capture bank is the one not live; swap on frame pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= 1'b0;
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < N_STREAMS; s++)
          for (int c = 0; c < N_CHANS; c++)
            mem_q[b][s][c] <= '0;
    end else begin
      if (we_i)    mem_q[~live_q][wstream_i][wchan_i] <= wdata_i;
      if (frame_i) live_q <= ~live_q;
    end
  end

  for (genvar s = 0; s < N_STREAMS; s++) begin : g_rp
    assign rd_data_o[s] = mem_q[live_q][rd_stream_i[s]][rd_chan_i[s]];
  end

  assign cpu_data_o = mem_q[live_q][cpu_stream_i][cpu_chan_i];
endmodule

// File: rtl/tdm_out_ctrl.sv
module tdm_out_ctrl
  import tdm_pkg::*;
#(
  parameter int N_STREAMS = 8,
  parameter int N_CHANS   = 32,
  parameter int DW        = 8,
  parameter int AW        = 8,
  localparam int SW       = $clog2(N_STREAMS),
  localparam int CHW      = $clog2(N_CHANS),
  localparam int BW       = $clog2(DW)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 frame_i,
  input  logic                 drive_en_i,
  input  logic                 in_we_i,
  input  logic [SW-1:0]        in_stream_i,
  input  logic [CHW-1:0]       in_chan_i,
  input  logic [DW-1:0]        in_data_i,
  input  logic                 cpu_we_i,
  input  logic [AW-1:0]        cpu_addr_i,
  input  logic [DW-1:0]        cpu_wdata_i,
  output logic [DW-1:0]        cpu_rdata_o,
  output logic [N_STREAMS-1:0] ser_o,
  output logic [N_STREAMS-1:0] ser_oe_o
);
  logic [CHW-1:0] chan;
  logic [BW-1:0]  bitpos;
  logic [DW-1:0]  hi_w   [N_STREAMS];
  logic [DW-1:0]  lo_w   [N_STREAMS];
  logic [DW-1:0]  ctrl_q;
  logic [DW-1:0]  conn_rdata;
  logic [SW-1:0]  src_stream [N_STREAMS];
  logic [CHW-1:0] src_chan   [N_STREAMS];
  logic [DW-1:0]  sw_data    [N_STREAMS];
  logic [DW-1:0]  dm_rdata;
  memsel_e        sel;

  tdm_frame_ctr #(.N_CHANS(N_CHANS), .DW(DW)) u_ctr (
    .clk_i, .rst_ni, .frame_i,
    .chan_o   (chan),
    .bitpos_o (bitpos)
  );

  tdm_conn_mem #(.N_STREAMS(N_STREAMS), .N_CHANS(N_CHANS), .DW(DW), .AW(AW)) u_conn (
    .clk_i, .rst_ni,
    .we_i    (cpu_we_i),
    .addr_i  (cpu_addr_i),
    .wdata_i (cpu_wdata_i),
    .chan_i  (chan),
    .hi_o    (hi_w),
    .lo_o    (lo_w),
    .ctrl_o  (ctrl_q),
    .rdata_o (conn_rdata)
  );

  tdm_data_mem #(.N_STREAMS(N_STREAMS), .N_CHANS(N_CHANS), .DW(DW)) u_dmem (
    .clk_i, .rst_ni, .frame_i,
    .we_i         (in_we_i),
    .wstream_i    (in_stream_i),
    .wchan_i      (in_chan_i),
    .wdata_i      (in_data_i),
    .rd_stream_i  (src_stream),
    .rd_chan_i    (src_chan),
    .rd_data_o    (sw_data),
    .cpu_stream_i (ctrl_q[SW-1:0]),
    .cpu_chan_i   (cpu_addr_i[CHW-1:0]),
    .cpu_data_o   (dm_rdata)
  );

  for (genvar s = 0; s < N_STREAMS; s++) begin : g_out
    logic          msg, en;
    logic [DW-1:0] byte_sel;
    assign src_stream[s] = hi_w[s][HI_SRC +: SW];
    assign src_chan[s]   = lo_w[s][CHW-1:0];
    assign msg           = hi_w[s][HI_MSG] | ctrl_q[CTRL_MSGALL];
    assign en            = (hi_w[s][HI_OE] | ctrl_q[CTRL_MSGALL]) & drive_en_i;
    assign byte_sel      = msg ? lo_w[s] : sw_data[s];
    assign ser_o[s]      = en & byte_sel[bitpos];
    assign ser_oe_o[s]   = en;
  end

  assign sel = memsel_e'(ctrl_q[CTRL_SEL +: 2]);

  always_comb begin
    if (!cpu_addr_i[AW-1])                             cpu_rdata_o = ctrl_q;
    else if (ctrl_q[CTRL_SPLIT])                       cpu_rdata_o = dm_rdata;
    else if (sel == SEL_LOW || sel == SEL_HIGH)        cpu_rdata_o = conn_rdata;
    else                                               cpu_rdata_o = dm_rdata;
  end
endmodule

// File: rtl/tdm_out_ctrl_chk.sv
module tdm_out_ctrl_chk #(
  parameter int N_STREAMS = 8,
  parameter int N_CHANS   = 32,
  parameter int DW        = 8,
  localparam int CHW      = $clog2(N_CHANS),
  localparam int BW       = $clog2(DW)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 frame_i,
  input logic                 drive_en_i,
  input logic                 msg_all_i,
  input logic [N_STREAMS-1:0] ser_o,
  input logic [N_STREAMS-1:0] ser_oe_o,
  input logic [CHW-1:0]       chan_i,
  input logic [BW-1:0]        bitpos_i
);
  p_hiz_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_o & ~ser_oe_o) == '0);

  p_global_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_en_i |-> ser_oe_o == '0);

  p_msg_all_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_all_i && drive_en_i) |-> &ser_oe_o);

  p_frame_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> (chan_i == '0 && bitpos_i == BW'(DW - 1)));

  p_bit_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_i && bitpos_i != '0) |=> bitpos_i == $past(bitpos_i) - 1'b1);
endmodule

bind tdm_out_ctrl tdm_out_ctrl_chk #(.N_STREAMS(N_STREAMS), .N_CHANS(N_CHANS), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .frame_i    (frame_i),
  .drive_en_i (drive_en_i),
  .msg_all_i  (ctrl_q[6]),
  .ser_o      (ser_o),
  .ser_oe_o   (ser_oe_o),
  .chan_i     (chan),
  .bitpos_i   (bitpos)
);

// File: tb/tdm_out_ctrl_tb.sv
module tdm_out_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       frame_i = 1'b0, drive_en_i = 1'b1;
  logic       in_we_i = 1'b0;
  logic [2:0] in_stream_i = '0;
  logic [4:0] in_chan_i = '0;
  logic [7:0] in_data_i = '0;
  logic       cpu_we_i = 1'b0;
  logic [7:0] cpu_addr_i = '0, cpu_wdata_i = '0;
  logic [7:0] cpu_rdata_o, ser_o, ser_oe_o;

  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  tdm_out_ctrl dut_i (
    .clk_i(clk), .rst_ni, .frame_i, .drive_en_i, .in_we_i, .in_stream_i,
    .in_chan_i, .in_data_i, .cpu_we_i, .cpu_addr_i, .cpu_wdata_i,
    .cpu_rdata_o, .ser_o, .ser_oe_o
  );

  // requirement-level model state
  logic [7:0] hi_m [8][32];
  logic [7:0] lo_m [8][32];
  logic [7:0] bank_m [2][8][32];
  logic       live_m = 1'b0;
  logic [7:0] ctrl_m = '0;
  logic [255:0] got_ser [8];
  logic [255:0] got_oe  [8];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] got, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic cpu_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); cpu_we_i = 1'b1; cpu_addr_i = a; cpu_wdata_i = d;
    @(negedge clk); cpu_we_i = 1'b0;
    if (!a[7]) ctrl_m = d;
    else if (ctrl_m[7]) lo_m[ctrl_m[2:0]][a[4:0]] = d;
    else if (ctrl_m[4:3] == 2'b01) lo_m[ctrl_m[2:0]][a[4:0]] = d;
    else if (ctrl_m[4:3] == 2'b10) hi_m[ctrl_m[2:0]][a[4:0]] = d;
  endtask

  task automatic cpu_rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); cpu_addr_i = a; #1;
    chk(cpu_rdata_o == exp, req, $sformatf("cpu read %0h", a), 256'(cpu_rdata_o), 256'(exp));
  endtask

  task automatic in_wr(input int s, input int c, input logic [7:0] d, input bit with_frame);
    @(negedge clk); in_we_i = 1'b1; in_stream_i = 3'(s); in_chan_i = 5'(c); in_data_i = d;
    frame_i = with_frame;
    @(negedge clk); in_we_i = 1'b0; frame_i = 1'b0;
    bank_m[~live_m][s][c] = d;
    if (with_frame) live_m = ~live_m;
  endtask

  function automatic logic [7:0] exp_byte(input int s, input int c);
    logic [7:0] h = hi_m[s][c], l = lo_m[s][c];
    if (h[2] | ctrl_m[6]) return l;
    return bank_m[live_m][h[5:3]][l[4:0]];
  endfunction

  function automatic bit exp_oe(input int s, input int c);
    return drive_en_i & (hi_m[s][c][0] | ctrl_m[6]);
  endfunction

  // pulse frame, capture 256 bits per stream, compare each stream
  task automatic grab(input string req);
    logic [255:0] es, eo;
    @(negedge clk); frame_i = 1'b1;
    @(negedge clk); frame_i = 1'b0;
    live_m = ~live_m;
    for (int b = 0; b < 256; b++) begin
      for (int s = 0; s < 8; s++) begin
        got_ser[s][b] = ser_o[s];
        got_oe[s][b]  = ser_oe_o[s];
      end
      if (b != 255) @(negedge clk);
    end
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c < 32; c++)
        for (int k = 0; k < 8; k++) begin
          eo[c*8+k] = exp_oe(s, c);
          es[c*8+k] = exp_oe(s, c) & exp_byte(s, c)[7-k];
        end
      chk(got_oe[s] == eo, req, $sformatf("stream %0d enables", s), got_oe[s], eo);
      chk(got_ser[s] == es, req, $sformatf("stream %0d data", s), got_ser[s], es);
    end
  endtask

  function automatic logic [7:0] byte_at(input int s, input int c);
    for (int k = 0; k < 8; k++) byte_at[7-k] = got_ser[s][c*8+k];
  endfunction

  task automatic t_reset;
    #1;
    chk(ser_oe_o == 8'h00, "R1", "oe after reset", 256'(ser_oe_o), 256'(0));
    chk(ser_o == 8'h00, "R1", "data after reset", 256'(ser_o), 256'(0));
    cpu_rd_chk(8'h00, 8'h00, "R1");
  endtask

  task automatic t_memsel;
    cpu_wr(8'h00, 8'h12); cpu_wr(8'h85, 8'h2D);
    cpu_wr(8'h00, 8'h0A); cpu_wr(8'h85, 8'h77);
    cpu_rd_chk(8'h85, 8'h77, "R10");
    cpu_rd_chk(8'h40, 8'h0A, "R10");
    cpu_wr(8'h00, 8'h12);
    cpu_rd_chk(8'h85, 8'h2D, "R10");
    cpu_wr(8'h00, 8'h02); cpu_wr(8'h85, 8'h55);
    cpu_rd_chk(8'h85, bank_m[live_m][2][5], "R10");
    cpu_wr(8'h00, 8'h1A);
    cpu_rd_chk(8'h85, bank_m[live_m][2][5], "R10");
    cpu_wr(8'h00, 8'h0A);
    cpu_rd_chk(8'h85, 8'h77, "R10");
  endtask

  task automatic t_switch;
    cpu_wr(8'h00, 8'h11); cpu_wr(8'h83, 8'h21);
    cpu_wr(8'h00, 8'h09); cpu_wr(8'h83, 8'h09);
    in_wr(4, 9, 8'hA6, 1'b0);
    cpu_wr(8'h00, 8'h04);
    cpu_rd_chk(8'h89, 8'h00, "R4");
    grab("R3");
    chk(byte_at(1, 3) == 8'hA6, "R2", "msb-first byte s1c3", 256'(byte_at(1, 3)), 256'(8'hA6));
    chk(got_oe[1][4*8] == 1'b0, "R6", "s1c4 disabled", 256'(got_oe[1][4*8]), 256'(0));
    cpu_rd_chk(8'h89, 8'hA6, "R4");
    grab("R4");
  endtask

  task automatic t_message;
    cpu_wr(8'h00, 8'h10); cpu_wr(8'h80, 8'h05);
    cpu_wr(8'h00, 8'h08); cpu_wr(8'h80, 8'h3C);
    cpu_wr(8'h00, 8'h17); cpu_wr(8'h9F, 8'h05);
    cpu_wr(8'h00, 8'h0F); cpu_wr(8'h9F, 8'h81);
    grab("R5");
    chk(byte_at(7, 31) == 8'h81, "R5", "s7c31 message", 256'(byte_at(7, 31)), 256'(8'h81));
    chk(byte_at(0, 0) == 8'h3C, "R5", "s0c0 message", 256'(byte_at(0, 0)), 256'(8'h3C));
    grab("R5");
  endtask

  task automatic t_disable;
    @(negedge clk); drive_en_i = 1'b0;
    grab("R7");
    chk(got_oe[2] == '0, "R7", "stream 2 silent", got_oe[2], '0);
    chk(got_ser[0] == '0, "R11", "stream 0 data low", got_ser[0], '0);
    @(negedge clk); drive_en_i = 1'b1;
  endtask

  task automatic t_msgall;
    cpu_wr(8'h00, 8'h40);
    grab("R8");
    chk(got_oe[3] == '1, "R8", "stream 3 all driven", got_oe[3], '1);
    chk(byte_at(1, 3) == 8'h09, "R8", "s1c3 forced message", 256'(byte_at(1, 3)), 256'(8'h09));
    cpu_wr(8'h00, 8'h00);
  endtask

  task automatic t_split;
    cpu_wr(8'h00, 8'h94); cpu_wr(8'h89, 8'h5A);
    cpu_rd_chk(8'h89, bank_m[live_m][4][9], "R9");
    cpu_wr(8'h00, 8'h0C);
    cpu_rd_chk(8'h89, 8'h5A, "R9");
    cpu_wr(8'h00, 8'h14);
    cpu_rd_chk(8'h89, 8'h00, "R9");
  endtask

  task automatic t_coincide;
    in_wr(6, 20, 8'hC3, 1'b1);
    cpu_wr(8'h00, 8'h06);
    cpu_rd_chk(8'h94, 8'hC3, "R4");
    cpu_wr(8'h00, 8'h10); cpu_wr(8'h81, 8'h31);
    cpu_wr(8'h00, 8'h08); cpu_wr(8'h81, 8'h14);
    grab("R4");
  endtask

  initial begin
    for (int s = 0; s < 8; s++)
      for (int c = 0; c < 32; c++) begin
        hi_m[s][c] = '0; lo_m[s][c] = '0;
        bank_m[0][s][c] = '0; bank_m[1][s][c] = '0;
      end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_memsel();
    t_switch();
    t_message();
    t_disable();
    t_msgall();
    t_split();
    t_coincide();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule